// File: doc/BRIEF.md
# Masked Element-Serial Vector ALU

This unit carries out one vector instruction at a time against an external vector register file. Once accepted, the instruction's elements are read one per cycle, in ascending index order, and pushed into a fixed-latency pipeline. There is no hazard check between elements, because the elements of one vector never depend on each other. Each result comes out of the last stage and is written back to the destination register. A mask bit chooses whether that write takes place. A separate test instruction produces a new mask instead of register data.

The surrounding datapath supplies the register indices, an optional scalar, the active length and the current mask together with a start pulse. It serves the unit's read requests combinationally and commits every write the unit presents. The end of the instruction is reported by a one-cycle done pulse. For a test instruction the same cycle carries the new mask, which the caller stores into its mask register.

Top module: `vec_serial_alu`

## Requirements
- R1: Opcode 0 (add) writes dest[i] = a[i] + b[i], wrapped modulo 2^W.
- R2: Opcode 1 (multiply) writes dest[i] = the low W bits of a[i] * b[i].
- R3: When use_scalar is high, the scalar input is the second operand for every element, in place of register src_b.
- R4: For add and multiply, an element whose bit in vmask is 0 is not written, so its slot keeps its old value. vmask is sampled in the accept cycle.
- R5: Only elements 0 to len-1 are processed. A vlen above NELEM acts as NELEM. A vlen of 0 gives no writes and a done pulse 2 cycles after the accept cycle.
- R6: Element i is written exactly 7+i cycles after the accept cycle. Writes come one per cycle, in ascending index order, and never reach indices at or beyond len.
- R7: done is a single-cycle pulse 7+len cycles after the accept cycle (len > 0). busy is high from the cycle after acceptance up to the cycle before done.
- R8: Opcode 2 (test) writes no register. It raises mask_we only in the done cycle, with mask_data bit i = (a[i] == 0) for i < len and 0 for i >= len, whatever vmask holds.
- R9: start is accepted only while busy is low. A start while busy has no effect.
- R10: After reset, busy, done, wr_en and mask_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin an instruction |
| op | input | 2 | 0 add, 1 multiply, 2 zero test |
| use_scalar | input | 1 | Take the second operand from scalar |
| src_a | input | RW | First source register |
| src_b | input | RW | Second source register |
| dst | input | RW | Destination register |
| scalar | input | W | Scalar operand |
| vlen | input | LW | Number of elements to process |
| vmask | input | NELEM | Write-enable mask per element |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_reg_a | output | RW | Register read by port A |
| rd_reg_b | output | RW | Register read by port B |
| rd_idx | output | IW | Element index read on both ports |
| rd_data_a | input | W | Element of rd_reg_a, same cycle |
| rd_data_b | input | W | Element of rd_reg_b, same cycle |
| wr_en | output | 1 | Commit wr_data this cycle |
| wr_reg | output | RW | Register written |
| wr_idx | output | IW | Element written |
| wr_data | output | W | Result value |
| mask_we | output | 1 | Load mask_data into the mask register |
| mask_data | output | NELEM | Mask produced by a test instruction |

## Verification
The assertions assume the read data answers the current rd_reg/rd_idx within the same cycle, and that start is only pulsed, never held through a whole instruction. The bench's register file model is combinational and commits writes on the falling edge, so it meets this assumption. Every start is dropped one cycle after it is raised, except in the test that deliberately raises start during a busy run. Source and destination registers may coincide. The bench includes such a case, which is safe only because element i is read six cycles before its write.

// File: rtl/vec_serial_alu.sv
module vec_serial_alu #(
  parameter int NREG  = 8,
  parameter int NELEM = 16,
  parameter int W     = 16,
  parameter int LAT   = 6,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(NELEM),
  localparam int LW = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic             use_scalar,
  input  logic [RW-1:0]    src_a,
  input  logic [RW-1:0]    src_b,
  input  logic [RW-1:0]    dst,
  input  logic [W-1:0]     scalar,
  input  logic [LW-1:0]    vlen,
  input  logic [NELEM-1:0] vmask,
  output logic             busy,
  output logic             done,
  output logic [RW-1:0]    rd_reg_a,
  output logic [RW-1:0]    rd_reg_b,
  output logic [IW-1:0]    rd_idx,
  input  logic [W-1:0]     rd_data_a,
  input  logic [W-1:0]     rd_data_b,
  output logic             wr_en,
  output logic [RW-1:0]    wr_reg,
  output logic [IW-1:0]    wr_idx,
  output logic [W-1:0]     wr_data,
  output logic             mask_we,
  output logic [NELEM-1:0] mask_data
);

  localparam logic [1:0] OP_ADD = 2'd0;
  localparam logic [1:0] OP_MUL = 2'd1;
  localparam logic [1:0] OP_TST = 2'd2;

  logic             busy_q, done_q, iss_q, us_q;
  logic [IW-1:0]    cnt_q;
  logic [1:0]       op_q;
  logic [RW-1:0]    sa_q, sb_q, d_q;
  logic [W-1:0]     sc_q;
  logic [LW-1:0]    len_q;
  logic [NELEM-1:0] msk_q, macc_q;

  logic [LAT-1:0]   pv, pm, pz;
  logic [W-1:0]     pr [LAT];
  logic [IW-1:0]    pi [LAT];

  logic [W-1:0]     opb, res1;
  logic [2*W-1:0]   prod;
  logic [LW-1:0]    vlen_c;
  logic             last_iss, drained;

  assign opb      = us_q ? sc_q : rd_data_b;
  assign prod     = rd_data_a * opb;
  assign res1     = (op_q == OP_MUL) ? prod[W-1:0] : rd_data_a + opb;
  assign vlen_c   = (vlen > LW'(NELEM)) ? LW'(NELEM) : vlen;
  assign last_iss = (LW'(cnt_q) + LW'(1)) == len_q;
  assign drained  = !iss_q && (pv[LAT-2:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iss_q  <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_ADD;
      us_q   <= 1'b0;
      sa_q   <= '0;
      sb_q   <= '0;
      d_q    <= '0;
      sc_q   <= '0;
      len_q  <= '0;
      msk_q  <= '0;
      macc_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          iss_q  <= (vlen_c != '0);
          cnt_q  <= '0;
          op_q   <= op;
          us_q   <= use_scalar;
          sa_q   <= src_a;
          sb_q   <= src_b;
          d_q    <= dst;
          sc_q   <= scalar;
          len_q  <= vlen_c;
          msk_q  <= vmask;
          macc_q <= '0;
        end
      end else begin
        if (iss_q) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_iss) iss_q <= 1'b0;
        end
        if (pv[LAT-1] && op_q == OP_TST) macc_q[pi[LAT-1]] <= pz[LAT-1];
        if (drained) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else        pv <= {pv[LAT-2:0], busy_q & iss_q};
  end

  always_ff @(posedge clk) begin
    pr[0] <= res1;
    pi[0] <= cnt_q;
    pz[0] <= (rd_data_a == '0);
    pm[0] <= msk_q[cnt_q];
    for (int s = 1; s < LAT; s++) begin
      pr[s] <= pr[s-1];
      pi[s] <= pi[s-1];
      pz[s] <= pz[s-1];
      pm[s] <= pm[s-1];
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign rd_reg_a  = sa_q;
  assign rd_reg_b  = sb_q;
  assign rd_idx    = cnt_q;
  assign wr_en     = pv[LAT-1] & pm[LAT-1] & (op_q != OP_TST);
  assign wr_reg    = d_q;
  assign wr_idx    = pi[LAT-1];
  assign wr_data   = pr[LAT-1];
  assign mask_we   = done_q & (op_q == OP_TST);
  assign mask_data = macc_q;

  // R7
  wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  mask_we_chk: assert property (@(posedge clk) disable iff (!rst_n) mask_we |-> (done && !wr_en));
  // R6
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv[LAT-1] && $past(pv[LAT-1])) |-> (pi[LAT-1] == $past(pi[LAT-1]) + 1'b1));
  // R6
  wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (LW'(wr_idx) < len_q));
  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);

endmodule

// File: tb/vec_serial_alu_tb.sv
module vec_serial_alu_tb_top;
  localparam int NREG = 8, NELEM = 16, W = 16;
  localparam int RW = $clog2(NREG), IW = $clog2(NELEM), LW = $clog2(NELEM + 1);

  logic clk = 0, rst_n = 0, start = 0, use_scalar = 0;
  logic [1:0] op = 0;
  logic [RW-1:0] src_a = 0, src_b = 0, dst = 0;
  logic [W-1:0] scalar = 0;
  logic [LW-1:0] vlen = 0;
  logic [NELEM-1:0] vmask = 0;
  logic busy, done, wr_en, mask_we;
  logic [RW-1:0] rd_reg_a, rd_reg_b, wr_reg;
  logic [IW-1:0] rd_idx, wr_idx;
  logic [W-1:0] rd_data_a, rd_data_b, wr_data;
  logic [NELEM-1:0] mask_data;

  logic [W-1:0] rf [NREG][NELEM];
  logic [W-1:0] ev [NELEM];
  int cyc = 0, ntest = 0, nfail = 0;
  int nwr, ndone, nmwe, first_wr, done_at, s0;
  logic [NELEM-1:0] mseen;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign rd_data_a = rf[rd_reg_a][rd_idx];
  assign rd_data_b = rf[rd_reg_b][rd_idx];

  vec_serial_alu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_scalar(use_scalar),
    .src_a(src_a), .src_b(src_b), .dst(dst), .scalar(scalar), .vlen(vlen), .vmask(vmask),
    .busy(busy), .done(done), .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b), .rd_idx(rd_idx),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_idx(wr_idx), .wr_data(wr_data), .mask_we(mask_we), .mask_data(mask_data));

  always @(negedge clk) begin
    if (wr_en) begin
      rf[wr_reg][wr_idx] = wr_data;
      if (nwr == 0) first_wr = cyc;
      nwr++;
    end
    if (done) begin ndone++; done_at = cyc; end
    if (mask_we) begin nmwe++; mseen = mask_data; end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int r, input int seed);
    for (int i = 0; i < NELEM; i++) rf[r][i] = W'(i * 37 + seed * 11 + 5);
  endtask

  task automatic launch(input logic [1:0] o, input logic us, input int a, input int b,
                        input int d, input logic [W-1:0] sc, input int vl,
                        input logic [NELEM-1:0] m);
    @(negedge clk);
    op = o; use_scalar = us; src_a = RW'(a); src_b = RW'(b); dst = RW'(d);
    scalar = sc; vlen = LW'(vl); vmask = m;
    nwr = 0; ndone = 0; nmwe = 0; s0 = cyc; start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); #1;
      if (ndone > 0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_vec(input string tag, input int d);
    for (int i = 0; i < NELEM; i++) chk(tag, rf[d][i], ev[i]);
  endtask

  task automatic t_reset;
    chk("R10 busy", busy, 0); chk("R10 done", done, 0);
    chk("R10 wr_en", wr_en, 0); chk("R10 mask_we", mask_we, 0);
  endtask

  task automatic t_add_full;
    fill(1, 1); fill(2, 2); fill(3, 9);
    for (int i = 0; i < NELEM; i++) ev[i] = rf[1][i] + rf[2][i];
    launch(2'd0, 0, 1, 2, 3, 0, 16, '1);
    cmp_vec("R1 add", 3);
    chk("R6 first write cycle", first_wr, s0 + 7);
    chk("R7 done cycle", done_at, s0 + 7 + 16);
    chk("R7 one done", ndone, 1);
    chk("R6 write count", nwr, 16);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < NELEM; i++) begin rf[1][i] = 16'hFFFF - W'(i); rf[2][i] = W'(3 + i); end
    for (int i = 0; i < NELEM; i++) ev[i] = rf[1][i] + rf[2][i];
    launch(2'd0, 0, 1, 2, 4, 0, 16, '1);
    cmp_vec("R1 wrap", 4);
  endtask

  task automatic t_mul_scalar_mask;
    logic [31:0] p;
    logic [NELEM-1:0] m = 16'b1010_0110_1101_0011;
    fill(1, 4); fill(2, 7); fill(5, 3);
    for (int i = 0; i < NELEM; i++) begin
      p = rf[1][i] * 32'h0123;
      ev[i] = (i < 10 && m[i]) ? p[15:0] : rf[5][i];
    end
    launch(2'd1, 1, 1, 2, 5, 16'h0123, 10, m);
    cmp_vec("R2 R3 R4 R5 mul scalar masked", 5);
    chk("R5 write count", nwr, $countones(m & 16'h03FF));
    chk("R7 done cycle len10", done_at, s0 + 17);
  endtask

  task automatic t_mul_vec;
    logic [31:0] p;
    fill(1, 12); fill(2, 13);
    for (int i = 0; i < NELEM; i++) begin p = rf[1][i] * rf[2][i]; ev[i] = p[15:0]; end
    launch(2'd1, 0, 1, 2, 6, 16'h7777, 16, '1);
    cmp_vec("R2 R3 mul vector", 6);
  endtask

  task automatic t_test;
    logic [NELEM-1:0] e = '0;
    fill(1, 5); fill(6, 6);
    rf[1][0] = 0; rf[1][3] = 0; rf[1][11] = 0; rf[1][13] = 0;
    for (int i = 0; i < 12; i++) e[i] = (rf[1][i] == 0);
    for (int i = 0; i < NELEM; i++) ev[i] = rf[6][i];
    launch(2'd2, 0, 1, 2, 6, 0, 12, '0);
    chk("R8 mask_data", mseen, e);
    chk("R8 one mask_we", nmwe, 1);
    chk("R8 no reg writes", nwr, 0);
    cmp_vec("R8 dest untouched", 6);
  endtask

  task automatic t_len0;
    fill(7, 8);
    for (int i = 0; i < NELEM; i++) ev[i] = rf[7][i];
    launch(2'd0, 0, 1, 2, 7, 0, 0, '1);
    chk("R5 len0 writes", nwr, 0);
    chk("R5 len0 done", done_at, s0 + 2);
    cmp_vec("R5 len0 dest", 7);
  endtask

  task automatic t_clamp;
    fill(1, 2); fill(0, 0);
    for (int i = 0; i < NELEM; i++) ev[i] = rf[1][i] + 16'h0010;
    launch(2'd0, 1, 1, 2, 0, 16'h0010, 20, '1);
    cmp_vec("R5 clamp", 0);
    chk("R5 clamp writes", nwr, 16);
    chk("R7 clamp done", done_at, s0 + 23);
  endtask

  task automatic t_inplace;
    fill(2, 3);
    for (int i = 0; i < NELEM; i++) ev[i] = rf[2][i] + rf[2][i];
    launch(2'd0, 0, 2, 2, 2, 0, 16, '1);
    cmp_vec("R1 in place", 2);
  endtask

  task automatic t_busy_start;
    fill(1, 1); fill(2, 2); fill(5, 10);
    for (int i = 0; i < NELEM; i++) ev[i] = rf[5][i];
    @(negedge clk);
    op = 0; use_scalar = 0; src_a = 1; src_b = 2; dst = 3; vlen = LW'(16); vmask = '1;
    nwr = 0; ndone = 0; nmwe = 0; s0 = cyc; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    dst = 5; op = 2'd2; start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); #1;
      if (ndone > 0) break;
    end
    repeat (3) @(negedge clk);
    chk("R9 one done", ndone, 1);
    chk("R9 no mask_we", nmwe, 0);
    chk("R9 done cycle", done_at, s0 + 23);
    cmp_vec("R9 other dest untouched", 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    t_add_full();
    t_wrap();
    t_mul_scalar_mask();
    t_mul_vec();
    t_test();
    t_len0();
    t_clamp();
    t_inplace();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    ntest++; nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule